// File: doc/BRIEF.md
# I2C Register-Map Target

This block is an I2C target that gives a bus host access to a byte-wide register file of 128 entries. It watches SCL and SDA through a synchroniser on the system clock. It recognises START, repeated START and STOP, and compares the first byte of each transaction with its own 7-bit bus address. A write transaction loads a register pointer from a memory-address byte and stores any further bytes at successive pointer values. A read transaction streams bytes out of the register file, starting at the pointer. The block drives SDA only by pulling it low, through a single enable output. The register file sits outside the block and is reached through an address, a write strobe, write data and combinational read data.

Only a narrow window of the map accepts writes. A byte sent to any other valid address is still acknowledged, but no write strobe is issued for it. When a read finishes, the pointer goes back to the last memory address the host sent, so a later read without an address phase starts again at that same register. Bytes are fetched from the register file one at a time, at the moment each is needed. The block takes no snapshot of multi-byte values.

Top module: `i2c_regmap_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `rf_wr_en` is 0 and `rf_addr` is 0.
- R2: The target acknowledges the first byte after a START when bits 7..1 equal the parameter `TGT_ADDR` (default 0x1B), with bit 0 giving the direction (0 for write, 1 for read). For any other address byte, SDA is left released for the rest of that transaction, including the acknowledge slots.
- R3: The memory-address byte of a write transaction is acknowledged when its value is 0x00 to 0x7F and not acknowledged when it is 0x80 or above.
- R4: Data bytes in one write transaction go to consecutive addresses. `rf_addr` advances by one after each accepted data byte.
- R5: A write strobe is issued only for addresses 0x20 to 0x39 inclusive. Data bytes sent to other addresses below 0x80 are still acknowledged.
- R6: After a memory-address byte of 0x80 or above, every following data byte is not acknowledged, no write strobe is issued and the pointer is not changed.
- R7: In a read transaction, the target sends the byte at the pointer, MSB first, and increments the pointer after each byte. It sends another byte after each host ACK. After a host NACK it leaves SDA released.
- R8: When a read ends (by host NACK, STOP or START), `rf_addr` returns to the last accepted memory address. A repeated START and a STOP followed by START both work between the address phase and the read.
- R9: Each byte sent in a read is taken from the register file when that byte starts. A change to the next register made while an earlier byte is being read shows up in the byte that is returned.
- R10: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R11: A START or STOP in the middle of a byte abandons that byte: nothing is written for it. After a START, address reception works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_addr | output | PTR_W | Register pointer, the register-file address |
| rf_wr_en | output | 1 | One-cycle write strobe |
| rf_wr_data | output | 8 | Byte to write |
| rf_rd_data | input | 8 | Byte stored at `rf_addr` |

## Verification
The hardest situations to reach are bus conditions that cut across a byte: a START or STOP after only a few data bits, and a register update that lands between two bytes of one read. The bench drives the bus bit by bit, so it can stop after any number of bits and issue a START or STOP while SCL is low. Between the two bytes of a read, it changes the next register through the bench's own register-file model. The timing is placed after the first byte has been loaded and before the second one is fetched.

// File: rtl/i2c_rmt_pkg.sv
package i2c_rmt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_IGNORE
  } fsm_st_e;

  typedef enum logic [1:0] {
    BK_DEV, BK_MEM, BK_DAT
  } byte_kind_e;

  // true when a register address lies inside the writable window
  function automatic logic in_window(input logic [7:0] a,
                                     input logic [7:0] lo,
                                     input logic [7:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/i2c_rmt_sampler.sv
module i2c_rmt_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_rmt_engine.sv
module i2c_rmt_engine
  import i2c_rmt_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h1B,
  parameter int         PTR_W    = 7,
  parameter logic [7:0] WIN_LO   = 8'h20,
  parameter logic [7:0] WIN_HI   = 8'h39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic [PTR_W-1:0] rf_addr,
  output logic             rf_wr_en,
  output logic [7:0]       rf_wr_data,
  input  logic [7:0]       rf_rd_data
);
  fsm_st_e    st;
  byte_kind_e kind;
  logic [2:0] bit_cnt;
  logic [7:0] sh, tx;
  logic       got, go_read, host_ack, oe;
  logic [PTR_W-1:0] ptr, base;
  logic       addr_ok, rd_mode;

  // named internal events
  logic rx_done, dev_hit, mem_valid, wr_fire, tx_done, rd_end;
  assign rx_done   = (st == ST_RX) && got && scl_fall;
  assign dev_hit   = (sh[7:1] == TGT_ADDR);
  assign mem_valid = ((sh >> PTR_W) == 8'd0);
  assign wr_fire   = rx_done && (kind == BK_DAT) && addr_ok &&
                     in_window(8'(ptr), WIN_LO, WIN_HI);
  assign tx_done   = (st == ST_TX) && scl_fall && (bit_cnt == 3'd7);
  assign rd_end    = ((st == ST_RACK) && scl_fall && !host_ack) ||
                     ((start_det || stop_det) && rd_mode);

  // bus-level sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= BK_DEV; bit_cnt <= '0; sh <= '0; tx <= '0;
      got <= 1'b0; go_read <= 1'b0; host_ack <= 1'b0; oe <= 1'b0;
    end else if (start_det) begin
      st <= ST_RX; kind <= BK_DEV; bit_cnt <= '0; got <= 1'b0; oe <= 1'b0;
    end else if (stop_det) begin
      st <= ST_IDLE; got <= 1'b0; oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && !got) begin
            sh      <= {sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) got <= 1'b1;
          end else if (rx_done) begin
            got     <= 1'b0;
            st      <= ST_ACK;
            go_read <= 1'b0;
            case (kind)
              BK_DEV: begin
                if (!dev_hit) st <= ST_IGNORE;
                else begin
                  oe      <= 1'b1;
                  kind    <= BK_MEM;
                  go_read <= sh[0];
                end
              end
              BK_MEM: begin
                oe   <= mem_valid;
                kind <= BK_DAT;
              end
              default: oe <= addr_ok;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (go_read) begin
              st <= ST_TX;
              tx <= rf_rd_data;
              oe <= ~rf_rd_data[7];
            end else begin
              st <= ST_RX;
              oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              oe <= 1'b0;
              st <= ST_RACK;
            end else begin
              tx <= {tx[6:0], 1'b1};
              oe <= ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) host_ack <= ~sda_s;
          else if (scl_fall) begin
            if (host_ack) begin
              st      <= ST_TX;
              tx      <= rf_rd_data;
              oe      <= ~rf_rd_data[7];
              bit_cnt <= '0;
            end else begin
              st <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // register pointer, restore point and transaction mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; base <= '0; addr_ok <= 1'b0; rd_mode <= 1'b0;
    end else if (rd_end) begin
      ptr     <= base;
      rd_mode <= 1'b0;
    end else if (rx_done && kind == BK_DEV && dev_hit) begin
      rd_mode <= sh[0];
    end else if (rx_done && kind == BK_MEM) begin
      addr_ok <= mem_valid;
      if (mem_valid) begin
        ptr  <= sh[PTR_W-1:0];
        base <= sh[PTR_W-1:0];
      end
    end else if ((rx_done && kind == BK_DAT && addr_ok) || tx_done) begin
      ptr <= ptr + 1'b1;
    end
  end

  assign sda_oe     = oe;
  assign rf_addr    = ptr;
  assign rf_wr_en   = wr_fire;
  assign rf_wr_data = sh;

  // assertions next to the logic they guard
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) |-> !$past(scl_s));

  p_wr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (8'(rf_addr) >= WIN_LO && 8'(rf_addr) <= WIN_HI));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |=> (rf_addr == $past(rf_addr) + 1'b1));

  p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGNORE) |-> !sda_oe);

  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> (rf_addr == $past(base)));

  p_start_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_RX && kind == BK_DEV && !sda_oe));

  p_bad_addr_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && kind == BK_DAT && !addr_ok) |=> !sda_oe);

endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target #(
  parameter logic [6:0] TGT_ADDR    = 7'h1B,
  parameter int         PTR_W       = 7,
  parameter logic [7:0] WIN_LO      = 8'h20,
  parameter logic [7:0] WIN_HI      = 8'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] rf_addr,
  output logic             rf_wr_en,
  output logic [7:0]       rf_wr_data,
  input  logic [7:0]       rf_rd_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_rmt_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rmt_engine #(
    .TGT_ADDR(TGT_ADDR), .PTR_W(PTR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .rf_addr(rf_addr), .rf_wr_en(rf_wr_en),
    .rf_wr_data(rf_wr_data), .rf_rd_data(rf_rd_data)
  );

endmodule

// File: tb/i2c_regmap_target_bench.sv
module i2c_regmap_target_bench;
  localparam int Q = 8;              // quarter SCL period in clk cycles
  localparam logic [7:0] DEV_W = 8'h36;
  localparam logic [7:0] DEV_R = 8'h37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;            // 200 MHz

  logic scl_h = 1'b1, sda_hl = 1'b0;
  logic scl_i, sda_i, sda_oe, rf_wr_en;
  logic [6:0] rf_addr;
  logic [7:0] rf_wr_data, rf_rd_data;
  assign scl_i = scl_h;
  assign sda_i = ~(sda_hl | sda_oe);

  i2c_regmap_target u_i2c_regmap_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
    .rf_addr(rf_addr), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
    .rf_rd_data(rf_rd_data)
  );

  // register file model behind the target
  logic [7:0] mem [128];
  logic [7:0] ref_m [128];
  logic       poke_en = 1'b0;
  logic [6:0] poke_addr = '0;
  logic [7:0] poke_val = '0;
  assign rf_rd_data = mem[rf_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (poke_en) mem[poke_addr] <= poke_val;
    else if (rf_wr_en) mem[rf_addr] <= rf_wr_data;
  end

  int n_chk = 0, n_fail = 0, r10_bad = 0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && scl_h) r10_bad++;
    prev_oe = sda_oe;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_hl = 1'b0; tick(Q); scl_h = 1'b1; tick(Q);
    sda_hl = 1'b1; tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_hl = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
    sda_hl = 1'b0; tick(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    sda_hl = ~b; tick(Q); scl_h = 1'b1; tick(2 * Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_hl = 1'b0; tick(Q); scl_h = 1'b1; tick(Q);
    ack = ~sda_i; tick(Q); scl_h = 1'b0; tick(Q);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    sda_hl = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl_h = 1'b1; tick(Q);
      b = {b[6:0], sda_i}; tick(Q); scl_h = 1'b0;
    end
    tick(Q); sda_hl = give_ack; scl_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(2 * Q); scl_h = 1'b0; tick(Q); sda_hl = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0] ma;
    logic [7:0] dat;
    logic       ack;   // expected ACK of address and data
    logic       wr;    // expected store
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'h20, 8'h11, 1'b1, 1'b1},
    '{8'h39, 8'h22, 1'b1, 1'b1},
    '{8'h1F, 8'h33, 1'b1, 1'b0},
    '{8'h3A, 8'h44, 1'b1, 1'b0},
    '{8'h7F, 8'h55, 1'b1, 1'b0},
    '{8'h80, 8'h66, 1'b0, 1'b0},
    '{8'h00, 8'h77, 1'b1, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [7:0] b;
    for (int i = 0; i < 128; i++) ref_m[i] = 8'(i * 7 + 3);
    tick(10);
    // R1 reset state
    check("R1 sda_oe", 32'(sda_oe), 0);
    check("R1 rf_wr_en", 32'(rf_wr_en), 0);
    check("R1 rf_addr", 32'(rf_addr), 0);
    rst_n = 1'b1;
    tick(4 * Q);

    // vector table: single-byte writes (R2, R3, R5, R6)
    foreach (VECS[k]) begin
      bus_start;
      put_byte(DEV_W, a0);
      put_byte(VECS[k].ma, a1);
      put_byte(VECS[k].dat, a2);
      bus_stop;
      check("R2 device ack", 32'(a0), 1);
      check("R3 mem-address ack", 32'(a1), 32'(VECS[k].ack));
      check("R6 data ack", 32'(a2), 32'(VECS[k].ack));
      if (VECS[k].wr) ref_m[VECS[k].ma[6:0]] = VECS[k].dat;
      check("R5 stored byte", 32'(mem[VECS[k].ma[6:0]]), 32'(ref_m[VECS[k].ma[6:0]]));
    end

    // R2 foreign address: no ACK, SDA stays released
    bus_start;
    put_byte(8'h50, a0);
    put_byte(8'h25, a1);
    bus_stop;
    check("R2 foreign addr nack", 32'(a0), 0);
    check("R2 released rest", 32'(a1), 0);
    check("R2 no store", 32'(mem[8'h25 & 8'h7F]), 32'(ref_m[8'h25]));

    // R4/R5 burst across the window edge
    bus_start;
    put_byte(DEV_W, a0); put_byte(8'h38, a0);
    put_byte(8'hC1, a1); put_byte(8'hC2, a2); put_byte(8'hC3, a3);
    bus_stop;
    ref_m[8'h38] = 8'hC1; ref_m[8'h39] = 8'hC2;
    check("R5 ack outside window", 32'(a3), 1);
    check("R4 burst 0x38", 32'(mem[8'h38]), 32'(ref_m[8'h38]));
    check("R4 burst 0x39", 32'(mem[8'h39]), 32'(ref_m[8'h39]));
    check("R5 0x3A untouched", 32'(mem[8'h3A]), 32'(ref_m[8'h3A]));
    check("R4 pointer after 3", 32'(rf_addr), 32'h3B);

    // R7/R8 read with repeated START
    bus_start;
    put_byte(DEV_W, a0); put_byte(8'h37, a0);
    bus_start;
    put_byte(DEV_R, a1);
    check("R7 read addr ack", 32'(a1), 1);
    get_byte(1'b1, b); check("R7 byte 0x37", 32'(b), 32'(ref_m[8'h37]));
    get_byte(1'b1, b); check("R7 byte 0x38", 32'(b), 32'(ref_m[8'h38]));
    get_byte(1'b0, b); check("R7 byte 0x39", 32'(b), 32'(ref_m[8'h39]));
    tick(Q);
    check("R7 released after nack", 32'(sda_oe), 0);
    bus_stop;
    check("R8 pointer restored", 32'(rf_addr), 32'h37);

    // R8 read without a new address phase
    bus_start;
    put_byte(DEV_R, a0);
    get_byte(1'b0, b);
    bus_stop;
    check("R8 reread start", 32'(b), 32'(ref_m[8'h37]));

    // R9 STOP then START setup, register changes between bytes
    bus_start;
    put_byte(DEV_W, a0); put_byte(8'h20, a0);
    bus_stop;
    bus_start;
    put_byte(DEV_R, a0);
    poke_addr = 7'h21; poke_val = 8'h5A; poke_en = 1'b1;
    tick(1); poke_en = 1'b0;
    ref_m[8'h21] = 8'h5A;
    get_byte(1'b1, b); check("R9 first byte", 32'(b), 32'(ref_m[8'h20]));
    get_byte(1'b0, b); check("R9 live second byte", 32'(b), 32'h5A);
    bus_stop;
    check("R8 restore after stop-start read", 32'(rf_addr), 32'h20);

    // R11 START in the middle of a data byte
    bus_start;
    put_byte(DEV_W, a0); put_byte(8'h30, a0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start;
    put_byte(DEV_W, a1);
    put_byte(8'h31, a0);
    put_byte(8'h77, a0);
    bus_stop;
    ref_m[8'h31] = 8'h77;
    check("R11 addr after restart", 32'(a1), 1);
    check("R11 abandoned byte", 32'(mem[8'h30]), 32'(ref_m[8'h30]));
    check("R11 next write", 32'(mem[8'h31]), 32'h77);

    // R11 STOP in the middle of a data byte
    bus_start;
    put_byte(DEV_W, a0); put_byte(8'h32, a0);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    bus_stop;
    check("R11 no write on stop", 32'(mem[8'h32]), 32'(ref_m[8'h32]));
    check("R11 pointer unchanged", 32'(rf_addr), 32'h32);

    // R6 invalid address burst
    bus_start;
    put_byte(DEV_W, a0); put_byte(8'h90, a1);
    put_byte(8'h12, a2); put_byte(8'h13, a3);
    bus_stop;
    check("R6 addr nack", 32'(a1), 0);
    check("R6 data nack 1", 32'(a2), 0);
    check("R6 data nack 2", 32'(a3), 0);
    check("R6 pointer kept", 32'(rf_addr), 32'h32);
    check("R6 no store", 32'(mem[8'h10]), 32'(ref_m[8'h10]));

    check("R10 sda_oe changes while SCL high", 32'(r10_bad), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule